// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block picks one winning interrupt line out of a set of pending lines. Every line carries a software-programmed urgency value, a mask bit and a class bit. The block keeps two competitions apart: lines whose class bit is 0 compete for the normal interrupt, and lines whose class bit is 1 compete for the fast interrupt. Each competition reports a winning line number and a flag that says whether any line took part.

The lines are grouped into banks of 32. A line's number is its flat position in the input vectors, which equals 32 times its bank plus its bit within the bank. The arbiter does not evaluate everything in one cycle. On a start request it captures the inputs and then walks through them `LANES` lines per clock. When the walk is complete it pulses a done strobe and updates its result outputs. The results then stay unchanged until the next scan finishes.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A line takes part in the normal competition when its pending bit is 1, its mask bit is 0 and its class bit is 0. It takes part in the fast competition under the same conditions with its class bit at 1. A masked line never wins.
- R2: Line i's urgency is `prio_i[i*PRIO_W +: PRIO_W]`. Among the lines taking part, the one with the numerically smallest value wins, and 0 is the most urgent.
- R3: When several lines taking part share the smallest value, the one with the highest line number wins.
- R4: The reported line number is the flat bit index i of the winner, which is 32*bank + bit. This holds for lines in every bank.
- R5: When no line takes part in a class, that class reports line 0 with its valid flag at 0.
- R6: A class's valid flag is 1 whenever at least one line took part, including the case where line 0 is the winner.
- R7: `done_o` is high for exactly one cycle. It rises STEPS rising edges after the edge that accepted `start_i`, where STEPS = 32*NUM_BANKS/LANES. The result outputs change only at that edge.
- R8: The result is computed from the inputs as they stood at the accepting edge. Input changes after that edge do not alter the result, and the outputs hold their values between done pulses.
- R9: A `start_i` that arrives while a scan is running is ignored: it neither restarts the scan nor produces an extra done pulse.
- R10: After reset, every output is 0.
- R11: The comparison uses the full `PRIO_W` width, so the values all-ones and all-ones-minus-one are ordered correctly.
- R12: The two classes are decided independently. Lines of one class never change the winner of the other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new scan; accepted only while idle |
| pending_i | input | 32*NUM_BANKS | Per-line pending bits |
| mask_i | input | 32*NUM_BANKS | Per-line mask bits (1 = masked) |
| class_i | input | 32*NUM_BANKS | Per-line class (0 = normal, 1 = fast) |
| prio_i | input | 32*NUM_BANKS*PRIO_W | Per-line urgency values, line i in bits [i*PRIO_W +: PRIO_W] |
| norm_line_o | output | clog2(32*NUM_BANKS) | Winning normal-class line number |
| norm_valid_o | output | 1 | A normal-class line took part |
| fast_line_o | output | clog2(32*NUM_BANKS) | Winning fast-class line number |
| fast_valid_o | output | 1 | A fast-class line took part |
| done_o | output | 1 | One-cycle strobe when new results are presented |

## Verification
The bench targets three groups of corner cases.

- **Ties and chunk boundaries.** It sets up ties that span chunks and banks. A design that keeps the first equal candidate would report the lowest tied line instead of the highest. It also places winners in the last bank and at the all-ones urgency value. A truncated index or a narrowed comparison would report the wrong bank or misorder 62 and 63.
- **Single-line edge cases.** A lone eligible line 0 must report valid=1, while an empty class must report valid=0 on line 0. A design that derives validity from the line number would confuse the two.
- **Changes during a scan.** It alters the inputs and repeats start while a scan is running. A design that reads live inputs, or that restarts on the second start, would return a mixed result, a late strobe or an extra strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // class slots used for the two independent competitions
    localparam int NUM_CLS  = 2;
    localparam int CLS_NORM = 0;
    localparam int CLS_FAST = 1;

    // lines per bank; line number = bank * BANK_LINES + bit
    localparam int BANK_LINES = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/irq_arb_elig.sv
module irq_arb_elig #(
    parameter int N = 32
) (
    input  logic [N-1:0] pending,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] cls,
    output logic [N-1:0] elig_norm,
    output logic [N-1:0] elig_fast
);

    logic [N-1:0] live;

    always_comb begin
        live      = pending & ~mask;
        elig_norm = live & ~cls;
        elig_fast = live & cls;
    end

endmodule

// File: rtl/irq_arb_chunk_pick.sv
module irq_arb_chunk_pick #(
    parameter int LANES  = 8,
    parameter int PRIO_W = 6,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]        elig,
    input  logic [LANES*PRIO_W-1:0] prio,
    output logic                    hit,
    output logic [PRIO_W-1:0]       best_prio,
    output logic [LANE_W-1:0]       best_lane
);

    // ascending walk with "<=" keeps the highest lane on a tie
    always_comb begin
        hit       = 1'b0;
        best_prio = '0;
        best_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (elig[i] && (!hit || prio[i*PRIO_W +: PRIO_W] <= best_prio)) begin
                hit       = 1'b1;
                best_prio = prio[i*PRIO_W +: PRIO_W];
                best_lane = LANE_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PRIO_W    = 6,
    parameter int LANES     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [32*NUM_BANKS-1:0]               pending_i,
    input  logic [32*NUM_BANKS-1:0]               mask_i,
    input  logic [32*NUM_BANKS-1:0]               class_i,
    input  logic [32*NUM_BANKS*PRIO_W-1:0]        prio_i,
    output logic [$clog2(32*NUM_BANKS)-1:0]       norm_line_o,
    output logic                                  norm_valid_o,
    output logic [$clog2(32*NUM_BANKS)-1:0]       fast_line_o,
    output logic                                  fast_valid_o,
    output logic                                  done_o
);

    localparam int NUM_LINES = BANK_LINES * NUM_BANKS;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int STEPS     = NUM_LINES / LANES;   // LANES must divide 32
    localparam int STEP_W    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int PBIT_W    = $clog2(NUM_LINES * PRIO_W);

    typedef struct packed {
        scan_state_e                               st;
        logic [STEP_W-1:0]                         step;
        logic [NUM_CLS-1:0][NUM_LINES-1:0]         elig;
        logic [NUM_LINES*PRIO_W-1:0]               prio;
        logic [NUM_CLS-1:0]                        run_hit;
        logic [NUM_CLS-1:0][PRIO_W-1:0]            run_prio;
        logic [NUM_CLS-1:0][IDX_W-1:0]             run_idx;
        logic [NUM_CLS-1:0]                        out_vld;
        logic [NUM_CLS-1:0][IDX_W-1:0]             out_line;
        logic                                      done;
    } arb_state_t;

    arb_state_t state_d, state_q;

    // ---------------- eligibility of the live inputs ----------------
    logic [NUM_LINES-1:0] live_norm, live_fast;

    irq_arb_elig #(.N(NUM_LINES)) u_elig (
        .pending   (pending_i),
        .mask      (mask_i),
        .cls       (class_i),
        .elig_norm (live_norm),
        .elig_fast (live_fast)
    );

    // ---------------- chunk selection from the snapshot ----------------
    logic [IDX_W-1:0]  base_line;
    logic [PBIT_W-1:0] prio_base;

    always_comb begin
        base_line = IDX_W'(int'(state_q.step) * LANES);
        prio_base = PBIT_W'(int'(state_q.step) * LANES * PRIO_W);
    end

    logic [NUM_CLS-1:0]             chunk_hit;
    logic [NUM_CLS-1:0][PRIO_W-1:0] chunk_prio;
    logic [NUM_CLS-1:0][LANE_W-1:0] chunk_lane;
    logic [LANES*PRIO_W-1:0]        chunk_prio_vec;

    assign chunk_prio_vec = state_q.prio[prio_base +: LANES*PRIO_W];

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        irq_arb_chunk_pick #(.LANES(LANES), .PRIO_W(PRIO_W)) u_pick (
            .elig      (state_q.elig[c][base_line +: LANES]),
            .prio      (chunk_prio_vec),
            .hit       (chunk_hit[c]),
            .best_prio (chunk_prio[c]),
            .best_lane (chunk_lane[c])
        );
    end

    // ---------------- next-state computation ----------------
    always_comb begin
        logic [NUM_CLS-1:0]             nh;
        logic [NUM_CLS-1:0][PRIO_W-1:0] np;
        logic [NUM_CLS-1:0][IDX_W-1:0]  ni;

        state_d      = state_q;
        state_d.done = 1'b0;
        nh = state_q.run_hit;
        np = state_q.run_prio;
        ni = state_q.run_idx;

        case (state_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    state_d.st             = ST_SCAN;
                    state_d.step           = '0;
                    state_d.elig[CLS_NORM] = live_norm;
                    state_d.elig[CLS_FAST] = live_fast;
                    state_d.prio           = prio_i;
                    state_d.run_hit        = '0;
                    state_d.run_prio       = '0;
                    state_d.run_idx        = '0;
                end
            end
            default: begin
                // later chunks hold higher lines, so an equal value replaces
                for (int c = 0; c < NUM_CLS; c++) begin
                    if (chunk_hit[c] &&
                        (!state_q.run_hit[c] || chunk_prio[c] <= state_q.run_prio[c])) begin
                        nh[c] = 1'b1;
                        np[c] = chunk_prio[c];
                        ni[c] = IDX_W'(base_line + IDX_W'(chunk_lane[c]));
                    end
                end
                state_d.run_hit  = nh;
                state_d.run_prio = np;
                state_d.run_idx  = ni;
                if (state_q.step == STEP_W'(STEPS - 1)) begin
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                    for (int c = 0; c < NUM_CLS; c++) begin
                        state_d.out_vld[c]  = nh[c];
                        state_d.out_line[c] = nh[c] ? ni[c] : '0;
                    end
                end else begin
                    state_d.step = state_q.step + STEP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign norm_line_o  = state_q.out_line[CLS_NORM];
    assign norm_valid_o = state_q.out_vld[CLS_NORM];
    assign fast_line_o  = state_q.out_line[CLS_FAST];
    assign fast_valid_o = state_q.out_vld[CLS_FAST];
    assign done_o       = state_q.done;

    // ---------------- assertions ----------------
    logic [STEP_W:0] chk_since;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              chk_since <= '0;
        else if (start_i && state_q.st == ST_IDLE) chk_since <= '0;
        else if (state_q.st == ST_SCAN)          chk_since <= chk_since + 1'b1;
    end

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> chk_since == (STEP_W+1)'(STEPS));

    a_r8_hold_between_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(norm_line_o) && $stable(norm_valid_o) &&
                     $stable(fast_line_o) && $stable(fast_valid_o)));

    a_r5_empty_norm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !norm_valid_o |-> norm_line_o == '0);

    a_r5_empty_fast_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_valid_o |-> fast_line_o == '0);

    a_r1_norm_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && norm_valid_o) |-> state_q.elig[CLS_NORM][norm_line_o]);

    a_r1_fast_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fast_valid_o) |-> state_q.elig[CLS_FAST][fast_line_o]);

    a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_SCAN && start_i) |=> (state_q.step != '0 || state_q.st == ST_IDLE));

endmodule

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;

    localparam int NB    = 3;
    localparam int PW    = 6;
    localparam int LN    = 8;
    localparam int NL    = 32 * NB;
    localparam int IW    = $clog2(NL);
    localparam int STEPS = NL / LN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [NL-1:0]    pending_i = '0;
    logic [NL-1:0]    mask_i = '0;
    logic [NL-1:0]    class_i = '0;
    logic [NL*PW-1:0] prio_i = '0;
    logic [IW-1:0]    norm_line_o, fast_line_o;
    logic             norm_valid_o, fast_valid_o, done_o;

    always #4 clk = ~clk;   // 125 MHz

    irq_prio_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW), .LANES(LN)) u_dut (
        .clk, .rst_n, .start_i, .pending_i, .mask_i, .class_i, .prio_i,
        .norm_line_o, .norm_valid_o, .fast_line_o, .fast_valid_o, .done_o
    );

    // bench-side line configuration
    bit          pend[NL];
    bit          msk[NL];
    bit          cls[NL];
    int unsigned pr[NL];

    typedef struct {
        int nl; bit nv; int fl; bit fv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad   = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // reference: smallest value first, then highest line with that value
    function automatic void ref_pick(input int c, output bit v, output int line);
        int unsigned best;
        best = 1 << PW;
        v = 1'b0;
        line = 0;
        for (int i = 0; i < NL; i++)
            if (pend[i] && !msk[i] && (int'(cls[i]) == c) && pr[i] < best) best = pr[i];
        for (int i = NL - 1; i >= 0; i--)
            if (!v && pend[i] && !msk[i] && (int'(cls[i]) == c) && pr[i] == best) begin
                v = 1'b1;
                line = i;
            end
    endfunction

    task automatic clear_cfg();
        for (int i = 0; i < NL; i++) begin
            pend[i] = 0; msk[i] = 0; cls[i] = 0; pr[i] = 0;
        end
    endtask

    task automatic apply_cfg();
        for (int i = 0; i < NL; i++) begin
            pending_i[i] = pend[i];
            mask_i[i]    = msk[i];
            class_i[i]   = cls[i];
            prio_i[i*PW +: PW] = PW'(pr[i]);
        end
    endtask

    task automatic push_expect(string tag, output exp_t e);
        ref_pick(0, e.nv, e.nl);
        ref_pick(1, e.fv, e.fl);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // driver: push expected, apply inputs with a start pulse, wait out the scan
    task automatic run_case(string tag);
        exp_t e;
        push_expect(tag, e);
        @(posedge clk); #1;
        apply_cfg();
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (STEPS + 2) @(posedge clk);
    endtask

    // monitor: pops and compares at each done strobe, checks latency
    bit run_seen = 0;
    int since = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (run_seen) since++;
            if (done_o) begin
                chk(run_seen && since == STEPS + 1, "R7", "done latency", since, STEPS + 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(norm_valid_o == e.nv && (!e.nv || int'(norm_line_o) == e.nl),
                        t, "normal winner", norm_valid_o ? int'(norm_line_o) : -1,
                        e.nv ? e.nl : -1);
                    chk(norm_valid_o || norm_line_o == '0, "R5", "normal empty line",
                        int'(norm_line_o), 0);
                    chk(fast_valid_o == e.fv && (!e.fv || int'(fast_line_o) == e.fl),
                        t, "fast winner", fast_valid_o ? int'(fast_line_o) : -1,
                        e.fv ? e.fl : -1);
                    chk(fast_valid_o || fast_line_o == '0, "R5", "fast empty line",
                        int'(fast_line_o), 0);
                end
                run_seen = 0;
            end
            if (start_i && !run_seen) begin
                run_seen = 1;
                since = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(norm_line_o == '0 && !norm_valid_o && fast_line_o == '0 && !fast_valid_o && !done_o,
            "R10", "reset outputs",
            int'(norm_line_o) + int'(fast_line_o) + norm_valid_o + fast_valid_o + done_o, 0);

        // R5: nothing pending
        clear_cfg();
        run_case("R5");

        // R6: lone line 0 wins, valid must be 1
        clear_cfg();
        pend[0] = 1; pr[0] = 5;
        run_case("R6");

        // R2 R4: urgency order across banks
        clear_cfg();
        pend[10] = 1; pr[10] = 3;
        pend[70] = 1; pr[70] = 1;
        pend[95] = 1; pr[95] = 2;
        pend[40] = 1; cls[40] = 1; pr[40] = 0;
        run_case("R2/R4");

        // R3 and R1: tie to highest line, masked urgent line ignored
        clear_cfg();
        pend[3] = 1; pr[3] = 7;
        pend[50] = 1; pr[50] = 7;
        pend[90] = 1; pr[90] = 7;
        pend[91] = 1; msk[91] = 1; pr[91] = 0;
        run_case("R3/R1");

        // R12: class separation
        clear_cfg();
        pend[20] = 1; cls[20] = 1; pr[20] = 0;
        pend[21] = 1; pr[21] = 9;
        pend[94] = 1; cls[94] = 1; pr[94] = 0;
        run_case("R12");

        // R11: full-width values
        clear_cfg();
        pend[5] = 1; pr[5] = (1 << PW) - 1;
        pend[6] = 1; pr[6] = (1 << PW) - 2;
        pend[80] = 1; cls[80] = 1; pr[80] = (1 << PW) - 1;
        run_case("R11");

        // R8 R9: inputs change and start repeats during a scan
        clear_cfg();
        pend[33] = 1; pr[33] = 4;
        pend[60] = 1; cls[60] = 1; pr[60] = 2;
        push_expect("R8", held);
        @(posedge clk); #1;
        apply_cfg();
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(posedge clk); #1;
        clear_cfg();
        pend[1] = 1; pr[1] = 0;
        pend[2] = 1; cls[2] = 1; pr[2] = 0;
        apply_cfg();
        start_i = 1'b1;            // R9: ignored while scanning
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (STEPS + 6) @(posedge clk);
        @(negedge clk);
        chk(norm_valid_o && int'(norm_line_o) == held.nl, "R8", "normal held",
            int'(norm_line_o), held.nl);
        chk(fast_valid_o && int'(fast_line_o) == held.fl, "R8", "fast held",
            int'(fast_line_o), held.fl);

        // random mixes, half with narrow urgency range to force ties
        for (int k = 0; k < 40; k++) begin
            clear_cfg();
            for (int i = 0; i < NL; i++) begin
                pend[i] = ($urandom % 4) == 0;
                msk[i]  = ($urandom % 4) == 0;
                cls[i]  = $urandom % 2;
                pr[i]   = (k % 2 == 0) ? ($urandom % 3) : ($urandom % (1 << PW));
            end
            run_case("R2/R3");
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R7", "missing done strobes", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule